// File: doc/BRIEF.md
# Saturating Integrator Input Debouncer

This block turns the bouncing level from a mechanical contact into a clean logic level. It does not time how long the input has been stable. Instead it integrates the input with an up/down counter that stops at both ends. The raw contact first passes through a two-flop synchronizer. On each sample tick the synchronized value is read: a 1 moves the counter up, and a 0 moves it down. The tick is a one-cycle pulse, usually about one millisecond apart.

The debounced level rises only when the counter reaches its top value. It falls only when the counter reaches zero. Between the two it keeps its last value, so the counter span acts as hysteresis. The block therefore behaves as a digital low-pass filter. With a top value of MAX_COUNT, the output can change no faster than once every MAX_COUNT ticks. A one-cycle press pulse marks every rise of the level, and a one-cycle release pulse marks every fall.

Top module: `hyst_debounce`

## Requirements
- R1: While reset is held, and in the first cycle after it, the level, press and release outputs are 0 and the internal count is 0 (released).
- R2: In a cycle where the tick is 0, the count and the level stay as they are, whatever the raw input does.
- R3: On a tick where the sampled input is 1, the count rises by one, unless it already equals MAX_COUNT, where it stays.
- R4: On a tick where the sampled input is 0, the count falls by one, unless it is already 0, where it stays.
- R5: The level goes from 0 to 1 only at the clock edge where the count becomes MAX_COUNT. From a count of 0 this takes exactly MAX_COUNT ticks that each sample 1.
- R6: The level goes from 1 to 0 only at the clock edge where the count becomes 0. At any count strictly between 0 and MAX_COUNT, the level keeps its previous value.
- R7: The press output is 1 for exactly the one cycle in which the level has just changed from 0 to 1.
- R8: The release output is 1 for exactly the one cycle in which the level has just changed from 1 to 0. Press and release are never 1 together.
- R9: If the sampled input alternates on every tick, starting from a count strictly between the end values, the level does not change.
- R10: The raw input passes through two flip-flops before it is sampled. A tick samples the raw value that was present two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle sample enable pulse |
| raw_i | input | 1 | Asynchronous raw contact level |
| level_o | output | 1 | Debounced level (1 = pressed) |
| press_o | output | 1 | One-cycle pulse on each rise of the level |
| release_o | output | 1 | One-cycle pulse on each fall of the level |

## Verification
Steady runs of 1 ticks show that the level rises exactly on the MAX_COUNT-th tick and not one tick sooner. Continuing past that point shows the counter saturates, because exactly MAX_COUNT zero ticks are then needed to release. A strictly alternating input starting from mid-range separates true hysteretic integration from a simple last-sample filter. Raw toggling without ticks, and ticks placed one and two cycles after a raw edge, expose the gating by the tick and the synchronizer latency. Random runs with random noise bursts and random tick spacing then compare every cycle against a counter model computed in the bench.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic int count_width(input int max_count);
    return $clog2(max_count + 1);
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbn_integrator.sv
module dbn_integrator
  import debounce_pkg::*;
#(
  parameter int MAX_COUNT = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             samp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             level_o,
  output logic             level_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_COUNT);

  step_e            step;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             level_q, level_nxt;

  always_comb begin
    step = STEP_HOLD;
    if (tick_i) begin
      if (samp_i && (cnt_q != CNT_TOP))    step = STEP_UP;
      else if (!samp_i && (cnt_q != '0))   step = STEP_DOWN;
    end
  end

  always_comb begin
    unique case (step)
      STEP_UP:   cnt_nxt = cnt_q + 1'b1;
      STEP_DOWN: cnt_nxt = cnt_q - 1'b1;
      default:   cnt_nxt = cnt_q;
    endcase
  end

  always_comb begin
    if (cnt_nxt == CNT_TOP)  level_nxt = 1'b1;
    else if (cnt_nxt == '0)  level_nxt = 1'b0;
    else                     level_nxt = level_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      level_q <= level_nxt;
    end
  end

  assign cnt_o       = cnt_q;
  assign level_o     = level_q;
  assign level_nxt_o = level_nxt;
endmodule

// File: rtl/dbn_edge.sv
module dbn_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  input  logic level_nxt_i,
  output logic press_o,
  output logic release_o
);
  logic press_q, release_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      press_q   <= 1'b0;
      release_q <= 1'b0;
    end else begin
      press_q   <= level_nxt_i & ~level_i;
      release_q <= ~level_nxt_i & level_i;
    end
  end

  assign press_o   = press_q;
  assign release_o = release_q;
endmodule

// File: rtl/hyst_debounce.sv
module hyst_debounce
  import debounce_pkg::*;
#(
  parameter int MAX_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o,
  output logic press_o,
  output logic release_o
);
  localparam int CNT_W = count_width(MAX_COUNT);

  logic             samp_w;
  logic [CNT_W-1:0] cnt_w;
  logic             level_w, level_nxt_w;

  dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_i),
    .q_o   (samp_w)
  );

  dbn_integrator #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_integ (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .samp_i      (samp_w),
    .cnt_o       (cnt_w),
    .level_o     (level_w),
    .level_nxt_o (level_nxt_w)
  );

  dbn_edge u_edge (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .level_i     (level_w),
    .level_nxt_i (level_nxt_w),
    .press_o     (press_o),
    .release_o   (release_o)
  );

  assign level_o = level_w;
endmodule

// File: rtl/hyst_debounce_chk.sv
module hyst_debounce_chk #(
  parameter int MAX_COUNT = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_i,
  input logic             samp,
  input logic [CNT_W-1:0] cnt,
  input logic             level,
  input logic             press,
  input logic             release_p
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_COUNT);

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (cnt == '0 && !level && !press && !release_p)); // R1

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> ($stable(cnt) && $stable(level))); // R2

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= CNT_TOP); // R3

  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && samp && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1)); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !samp && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4

  AST_RISE_AT_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(level) |-> (cnt == CNT_TOP)); // R5

  AST_FALL_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(level) |-> (cnt == '0)); // R6

  AST_PRESS_MARKS_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    press |-> (level && !$past(level))); // R7

  AST_RELEASE_MARKS_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    release_p |-> (!level && $past(level))); // R8

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({press, release_p})); // R8
endmodule

bind hyst_debounce hyst_debounce_chk #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .tick_i    (tick_i),
  .samp      (samp_w),
  .cnt       (cnt_w),
  .level     (level_w),
  .press     (press_o),
  .release_p (release_o)
);

// File: tb/hyst_debounce_test.sv
module hyst_debounce_test;
  localparam int MAXC = 8;

  logic clk = 1'b0;
  logic rst, tick, raw;
  logic level, press, release_p;

  int vectors = 0;
  int fails   = 0;
  string tag  = "R1";
  bit done    = 1'b0;

  int m_cnt;
  bit m_level, m_press, m_rel, m_s1, m_s2;

  always #5 clk = ~clk;

  hyst_debounce #(.MAX_COUNT(MAXC), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .raw_i(raw),
    .level_o(level), .press_o(press), .release_o(release_p)
  );

  // Requirement model: two-stage sampler, saturating count, end-stop level, edge pulses
  function automatic void model_step(input bit r, input bit t, input bit x);
    bit prev;
    if (r) begin
      m_cnt = 0; m_level = 0; m_press = 0; m_rel = 0; m_s1 = 0; m_s2 = 0;
      return;
    end
    prev = m_level;
    if (t) begin
      if (m_s2 && m_cnt < MAXC)       m_cnt++;
      else if (!m_s2 && m_cnt > 0)    m_cnt--;
    end
    if (m_cnt == MAXC)  m_level = 1;
    else if (m_cnt == 0) m_level = 0;
    m_press = m_level && !prev;
    m_rel   = !m_level && prev;
    m_s2 = m_s1;
    m_s1 = x;
  endfunction

  task automatic check(input string req, input bit act, input bit exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit r, input bit t, input bit x);
    rst = r; tick = t; raw = x;
    @(posedge clk);
    #1;
    model_step(r, t, x);
    check(tag, level, m_level, "level");
    check(tag, press, m_press, "press");
    check(tag, release_p, m_rel, "release");
  endtask

  // one tick sampling value x, after enough quiet cycles for the sync chain to settle
  task automatic tick_with(input bit x);
    cyc(0, 0, x); cyc(0, 0, x); cyc(0, 1, x);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit r_now;
    void'($urandom(32'h5EED));
    // R1: reset state
    tag = "R1";
    rst = 1; tick = 0; raw = 1;
    repeat (3) cyc(1, 1, 1);
    cyc(0, 0, 0);
    check("R1", level, 1'b0, "level after reset");

    // R2: raw toggling with no ticks changes nothing
    tag = "R2";
    for (int i = 0; i < 20; i++) cyc(0, 0, i[0]);
    check("R2", level, 1'b0, "level without ticks");

    // R10: ticks one edge after a raw rise still see 0; third edge sees 1
    tag = "R10";
    cyc(0, 0, 0); cyc(0, 0, 0);
    cyc(0, 0, 1);     // raw goes high
    cyc(0, 1, 1);     // s2 still 0 -> no count
    cyc(0, 1, 1);     // s2 now 1 -> count 1
    for (int i = 0; i < MAXC - 2; i++) cyc(0, 1, 1);
    check("R10", level, 1'b0, "level one tick before top");
    cyc(0, 1, 1);
    check("R10", level, 1'b1, "level at top after sync latency");
    check("R7", press, 1'b1, "press at rise");
    cyc(0, 0, 1);
    check("R7", press, 1'b0, "press lasts one cycle");

    // R3: overdrive saturates; R4/R6/R8: exactly MAXC zero ticks release
    tag = "R3";
    for (int i = 0; i < 10; i++) tick_with(1);
    tag = "R6";
    for (int i = 0; i < MAXC - 1; i++) tick_with(0);
    check("R6", level, 1'b1, "level held one tick short of zero");
    tag = "R8";
    tick_with(0);
    check("R8", release_p, 1'b1, "release when count reaches zero");
    check("R4", level, 1'b0, "level after saturating count drained");
    tag = "R4";
    for (int i = 0; i < 5; i++) tick_with(0);
    // R5: from zero, MAXC-1 ones do not press, MAXC-th does
    tag = "R5";
    for (int i = 0; i < MAXC - 1; i++) tick_with(1);
    check("R5", level, 1'b0, "level before MAXC ones");
    tick_with(1);
    check("R5", level, 1'b1, "level after MAXC ones");

    // R9: bring count to mid-range, then alternate
    tag = "R9";
    for (int i = 0; i < MAXC / 2; i++) tick_with(0);
    for (int i = 0; i < 40; i++) tick_with(i[0]);
    check("R9", level, 1'b1, "level held under alternating input");

    // random runs with noise bursts and random tick spacing
    tag = "R2/R3/R4/R5/R6";
    r_now = 0;
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 16) == 0) r_now = ~r_now;
      if (((i / 200) % 2) == 1 && ($urandom % 3) == 0) cyc(0, ($urandom % 4) == 0, ~r_now);
      else cyc(0, ($urandom % 4) == 0, r_now);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule